// File: doc/BRIEF.md
# Serial Start-of-Frame Byte Framer

This block sits on the receive side of a serial link, after the decoder that recovers NRZ data and a bit-rate timing pulse. It watches the alternating preamble. When the two consecutive ones that close the start-of-frame delimiter arrive, it raises a framing mark. After that the mark flips once every eight accepted bits. Logic further downstream can then deserialise the packet into bytes with no framing counter of its own.

The block runs on a system clock. Each received bit comes with a one-cycle strobe, and a carrier signal covers the whole frame. The data bit passes straight through to the outputs for the full length of the packet. The strobe also passes through, gated so that it is active only while the carrier is present. A count of completed byte boundaries is provided for a companion block that times a reject window.

Top module: `sfd_byte_framer`

## Requirements
- R1: After reset the framing mark is low, the byte count is zero and the block is searching for a delimiter.
- R2: A bit is accepted only on a cycle where both `bit_strobe_i` and `carrier_i` are 1. While searching, an accepted 1 ends the delimiter if the previous accepted bit was also 1 and that previous bit closed an unbroken alternating run of at least PRE_MIN bits (default 8). On the clock edge that accepts this bit, the mark goes high and the byte count goes to zero.
- R3: A pair of ones that follows an alternating run shorter than PRE_MIN bits does not declare a delimiter, and the mark stays low. Such a run includes a plain 1,0,1,0,1,0,1,1 with no preamble before it.
- R4: After the delimiter, the mark inverts on the edge that accepts every eighth bit. The byte count rises by one on each such inversion.
- R5: The byte count saturates at all ones (255 with CNT_W=8). The mark keeps inverting at every byte boundary after saturation.
- R6: Any clock edge with `carrier_i` at 0 returns the block to the search state, with the mark low and the count zero. This holds whatever the strobe does.
- R7: An edge that has the carrier but no strobe leaves the mark and the byte count unchanged.
- R8: `rx_bit_o` equals `rx_bit_i`, and `bit_strobe_o` equals `bit_strobe_i` AND `carrier_i`, both combinationally.
- R9: Once the delimiter is found, further pairs of ones in the packet data do not restart framing. The mark follows byte timing only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| carrier_i | input | 1 | Receive activity; high for the whole frame |
| bit_strobe_i | input | 1 | One-cycle pulse per recovered bit |
| rx_bit_i | input | 1 | Recovered NRZ data bit |
| rx_bit_o | output | 1 | Data bit passed through |
| bit_strobe_o | output | 1 | Bit strobe, gated by carrier |
| frame_mark_o | output | 1 | Framing mark: rises at the delimiter, flips every byte |
| byte_count_o | output | CNT_W | Byte boundaries since the delimiter, saturating |

## Verification
The assertions assume that the reset is held low at time zero and is released synchronously to the clock. They also assume the strobe and the carrier change only between clock edges, so that every accepted bit is one clean cycle. The bench drives every input from the falling edge and holds it through the rising edge. It drops the carrier between frames, in the same way the decoder ends a frame. Gaps without a strobe are inserted inside a frame to exercise the hold behaviour.

// File: rtl/sfd_framer_pkg.sv
package sfd_framer_pkg;
    typedef enum logic {
        ST_HUNT  = 1'b0,
        ST_BYTES = 1'b1
    } frm_state_e;
endpackage

// File: rtl/sfd_hunt.sv
module sfd_hunt #(
    parameter int PRE_MIN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic flush_i,
    input  logic step_i,
    input  logic bit_i,
    output logic hit_o
);
    localparam int RUN_W = $clog2(PRE_MIN + 1);

    typedef struct packed {
        logic             have;
        logic             last;
        logic [RUN_W-1:0] run;
    } hunt_t;

    hunt_t hunt_d, hunt_q;

    always_comb begin
        hunt_d = hunt_q;
        hit_o  = 1'b0;
        if (flush_i) begin
            hunt_d = '0;
        end else if (step_i) begin
            if (hunt_q.have && hunt_q.last && bit_i &&
                hunt_q.run >= RUN_W'(PRE_MIN)) begin
                hit_o  = 1'b1;
                hunt_d = '0;
            end else begin
                hunt_d.have = 1'b1;
                hunt_d.last = bit_i;
                if (hunt_q.have && (hunt_q.last != bit_i)) begin
                    if (hunt_q.run < RUN_W'(PRE_MIN))
                        hunt_d.run = hunt_q.run + RUN_W'(1);
                end else begin
                    hunt_d.run = RUN_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hunt_q <= '0;
        else        hunt_q <= hunt_d;
    end

    // R3: a delimiter is never declared on the very first bit after a flush
    a_r3_needs_history: assert property (@(posedge clk) disable iff (!rst_n)
        $past(flush_i) |-> !hit_o);
endmodule

// File: rtl/sfd_byte_mark.sv
module sfd_byte_mark #(
    parameter int BYTE_BITS = 8,
    parameter int CNT_W     = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             start_i,
    input  logic             step_i,
    output logic             mark_o,
    output logic [CNT_W-1:0] count_o
);
    localparam int BIT_W = (BYTE_BITS > 1) ? $clog2(BYTE_BITS) : 1;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic             mark;
        logic [BIT_W-1:0] pos;
        logic [CNT_W-1:0] cnt;
    } mark_t;

    mark_t mk_d, mk_q;

    always_comb begin
        mk_d = mk_q;
        if (clear_i) begin
            mk_d = '0;
        end else if (start_i) begin
            mk_d.mark = 1'b1;
            mk_d.pos  = '0;
            mk_d.cnt  = '0;
        end else if (step_i) begin
            if (mk_q.pos == BIT_W'(BYTE_BITS - 1)) begin
                mk_d.pos  = '0;
                mk_d.mark = ~mk_q.mark;
                if (mk_q.cnt != CNT_MAX)
                    mk_d.cnt = mk_q.cnt + CNT_W'(1);
            end else begin
                mk_d.pos = mk_q.pos + BIT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mk_q <= '0;
        else        mk_q <= mk_d;
    end

    assign mark_o  = mk_q.mark;
    assign count_o = mk_q.cnt;

    // R5: the count never wraps; it only grows, holds, or is cleared
    a_r5_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && !start_i) |=> (count_o >= $past(count_o)));

    // R4: the count moves only on a cycle where the mark flips
    a_r4_count_with_mark: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && !start_i && step_i && count_o != CNT_MAX)
            |=> ((count_o != $past(count_o)) == (mark_o != $past(mark_o))));
endmodule

// File: rtl/sfd_byte_framer.sv
module sfd_byte_framer
    import sfd_framer_pkg::*;
#(
    parameter int PRE_MIN   = 8,
    parameter int BYTE_BITS = 8,
    parameter int CNT_W     = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             carrier_i,
    input  logic             bit_strobe_i,
    input  logic             rx_bit_i,
    output logic             rx_bit_o,
    output logic             bit_strobe_o,
    output logic             frame_mark_o,
    output logic [CNT_W-1:0] byte_count_o
);
    frm_state_e state_d, state_q;
    logic accept, hunting, hit;

    assign accept  = bit_strobe_i & carrier_i;
    assign hunting = (state_q == ST_HUNT);

    sfd_hunt #(.PRE_MIN(PRE_MIN)) hunt_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush_i (!carrier_i || !hunting),
        .step_i  (accept && hunting),
        .bit_i   (rx_bit_i),
        .hit_o   (hit)
    );

    sfd_byte_mark #(.BYTE_BITS(BYTE_BITS), .CNT_W(CNT_W)) mark_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (!carrier_i),
        .start_i (hit),
        .step_i  (accept && !hunting),
        .mark_o  (frame_mark_o),
        .count_o (byte_count_o)
    );

    always_comb begin
        state_d = state_q;
        if (!carrier_i)  state_d = ST_HUNT;
        else if (hit)    state_d = ST_BYTES;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HUNT;
        else        state_q <= state_d;
    end

    assign rx_bit_o     = rx_bit_i;
    assign bit_strobe_o = accept;

    // R6: loss of carrier clears the framing output on the next edge
    a_r6_carrier_drop: assert property (@(posedge clk) disable iff (!rst_n)
        !carrier_i |=> (!frame_mark_o && byte_count_o == '0 && state_q == ST_HUNT));

    // R2: entering the byte phase starts with the mark high and count zero
    a_r2_enter_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (hunting && carrier_i && hit) |=> (frame_mark_o && byte_count_o == '0));

    // R7: no strobe with carrier present means outputs hold
    a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (carrier_i && !bit_strobe_i) |=> ($stable(frame_mark_o) && $stable(byte_count_o)));

    // R9: in the byte phase the block never falls back to hunting while carrier stays
    a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (!hunting && carrier_i) |=> (state_q == ST_BYTES));
endmodule

// File: tb/sfd_byte_framer_tb.sv
module sfd_byte_framer_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       carrier = 1'b0, strobe = 1'b0, rbit = 1'b0;
    logic       bit_out, strb_out, mark;
    logic [7:0] cnt;
    int         n_run = 0, n_fail = 0;

    always #10 clk = ~clk;

    sfd_byte_framer dut_i (
        .clk(clk), .rst_n(rst_n), .carrier_i(carrier), .bit_strobe_i(strobe),
        .rx_bit_i(rbit), .rx_bit_o(bit_out), .bit_strobe_o(strb_out),
        .frame_mark_o(mark), .byte_count_o(cnt)
    );

    // {preamble length, expect delimiter, data bits are ones}
    localparam int VEC [6][3] = '{
        '{0, 0, 0}, '{6, 0, 0}, '{7, 0, 1}, '{8, 1, 0}, '{12, 1, 0}, '{56, 1, 1}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // drive at falling edge, let the rising edge take it, sample mid high phase
    task automatic put(input logic c, input logic s, input logic b);
        @(negedge clk);
        carrier = c; strobe = s; rbit = b;
        @(posedge clk);
        #5;
    endtask

    task automatic send_pre(input int len);
        for (int i = 0; i < len; i++) put(1'b1, 1'b1, (i % 2 == 0));
        put(1'b1, 1'b1, 1'b1);
        put(1'b1, 1'b1, 1'b1);
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #35 rst_n = 1'b1;
        #5;
        chk("R1 mark", mark, 0);
        chk("R1 count", cnt, 0);

        // table walk
        for (int v = 0; v < 6; v++) begin
            send_pre(VEC[v][0]);
            chk(VEC[v][1] ? "R2 mark rise" : "R3 no delimiter", mark, VEC[v][1]);
            chk("R2 count zero", cnt, 0);
            for (int k = 1; k <= 16; k++) begin
                put(1'b1, 1'b1, VEC[v][2] != 0);
                if (VEC[v][1] != 0) begin
                    chk(VEC[v][2] ? "R9 mark" : "R4 mark", mark, ((k / 8) % 2 == 0));
                    chk("R4 count", cnt, k / 8);
                end else begin
                    chk("R3 mark stays low", mark, 0);
                end
            end
            put(1'b0, 1'b0, 1'b0);
            chk("R6 mark cleared", mark, 0);
            chk("R6 count cleared", cnt, 0);
        end

        // R7 hold during strobe gaps, mid-byte
        send_pre(8);
        for (int k = 0; k < 5; k++) put(1'b1, 1'b1, 1'b0);
        for (int k = 0; k < 4; k++) put(1'b1, 1'b0, 1'b1);
        chk("R7 hold mark", mark, 1);
        chk("R7 hold count", cnt, 0);
        for (int k = 0; k < 3; k++) put(1'b1, 1'b1, 1'b0);
        chk("R7 resume toggle", mark, 0);
        chk("R7 resume count", cnt, 1);

        // R8 passthrough
        @(negedge clk); carrier = 1'b1; strobe = 1'b1; rbit = 1'b1; #1;
        chk("R8 data", bit_out, 1);
        chk("R8 strobe", strb_out, 1);
        carrier = 1'b0; rbit = 1'b0; #1;
        chk("R8 data low", bit_out, 0);
        chk("R8 strobe gated", strb_out, 0);

        // R6 with strobe active while carrier low
        put(1'b0, 1'b1, 1'b1);
        chk("R6 strobe ignored", mark, 0);

        // R5 saturation: 300 bytes
        send_pre(10);
        for (int k = 0; k < 300 * 8; k++) put(1'b1, 1'b1, 1'b0);
        chk("R5 count saturated", cnt, 255);
        chk("R5 mark still toggles", mark, 1);
        for (int k = 0; k < 8; k++) put(1'b1, 1'b1, 1'b0);
        chk("R5 mark after sat", mark, 0);
        chk("R5 count held", cnt, 255);
        put(1'b0, 1'b0, 1'b0);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule